// File: doc/BRIEF.md
# Interrupt Flag, Mask and Vector Unit

The unit holds the pending state of three external interrupt sources and an 8-bit enable register that covers both external and timer sources. Each cycle it combines the pending external flags and two level-sensitive timer request inputs with their enable bits and a global interrupt-enable input. It then selects the request with the lowest vector address and presents that address to the CPU. When the CPU acknowledges, the unit clears the external flag whose vector was granted. The timer requests are levels owned by the timer logic, so an acknowledge leaves them alone.

Software reaches both registers through a single-cycle read/write port. A write of ones to the flag register clears pending flags, and the enable register is ordinary read/write storage. Edge detection on the pins, the timers and the CPU sit outside this unit. A one-cycle high on an event input counts as one trigger.

Top module: `irq_vec_unit`

## Requirements
- R1: After reset the flag register reads 0x00, the enable register reads 0x00, irq_req_o is 0 and irq_vec_o is 0x00.
- R2: A high on ext_evt_i[n] during a clock edge sets pending flag n. The flags read back at address 0 in these bits: source 1 in bit 7, source 0 in bit 6 and source 2 in bit 5.
- R3: Bits 4..0 of the flag register always read 0, and writes to them have no effect.
- R4: A write to address 0 clears every flag whose bit in the write data is 1. A flag whose bit is 0 is left unchanged.
- R5: If an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R6: Address 1 is the enable register. All 8 bits are read/write, and a write shows on reg_rdata_o from the next cycle.
- R7: A source requests only when gie_i is 1 and its enable bit is 1. External source n uses enable bit n (n = 0..2). The compare-A timer request tmr_req_i[0] uses bit 6, and the overflow timer request tmr_req_i[1] uses bit 7.
- R8: The vector addresses are 0x02 for external source 0, 0x04 for source 1, 0x06 for source 2, 0x0E for compare-A and 0x12 for overflow. irq_vec_o is 0x00 and irq_req_o is 0 when no source requests.
- R9: When several sources request at once, the one with the lowest vector address is presented.
- R10: An irq_ack_i high at a clock edge clears only the external flag of the vector presented at that edge. Timer requests are not affected, and an event arriving in the same cycle keeps its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_evt_i | input | 3 | Trigger events, bit n is external source n |
| tmr_req_i | input | 2 | Timer request levels: bit 0 compare-A, bit 1 overflow |
| gie_i | input | 1 | Global interrupt enable |
| reg_addr_i | input | 1 | Register select: 0 flags, 1 enables |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| irq_req_o | output | 1 | Request to the CPU |
| irq_vec_o | output | 8 | Vector address of the winning request |
| irq_ack_i | input | 1 | CPU acknowledge of the presented vector |

## Verification
Flag and enable changes from events, writes and acknowledges are due one clock edge after the stimulus. irq_req_o, irq_vec_o and reg_rdata_o follow that register state, gie_i, the timer inputs and the address with no further delay. The bench therefore drives every input just after a falling edge. It reads state-derived results after the next falling edge, when exactly one rising edge has passed, and reads purely combinational results a few nanoseconds after the drive in the same half cycle. Same-cycle collisions between an event and a software clear, or between an event and an acknowledge, are driven in one cycle and read back one edge later.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int DATA_W = 8;
  localparam int VEC_W  = 8;
  localparam int N_EXT  = 3;
  localparam int N_TMR  = 2;
  localparam int N_SRC  = N_EXT + N_TMR;
  localparam int IDX_W  = $clog2(N_SRC);

  // source index = priority rank, 0 highest (lowest vector)
  function automatic logic [VEC_W-1:0] vec_of(input int idx);
    case (idx)
      0:       vec_of = VEC_W'(8'h02);
      1:       vec_of = VEC_W'(8'h04);
      2:       vec_of = VEC_W'(8'h06);
      3:       vec_of = VEC_W'(8'h0E);
      4:       vec_of = VEC_W'(8'h12);
      default: vec_of = '0;
    endcase
  endfunction

  function automatic int flag_pos(input int ext);
    case (ext)
      0:       flag_pos = 6;
      1:       flag_pos = 7;
      default: flag_pos = 5;
    endcase
  endfunction

  function automatic int en_pos(input int idx);
    if (idx < N_EXT) en_pos = idx;
    else if (idx == N_EXT) en_pos = 6;
    else en_pos = 7;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_sw_i,
  input  logic [N-1:0] clr_hw_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      flag_o[g] <= 1'b0;
      else if (set_i[g])                flag_o[g] <= 1'b1;
      else if (clr_sw_i[g] || clr_hw_i[g]) flag_o[g] <= 1'b0;
    end

    // R2 R5
    evt_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_o[g]);

    // R4 R10
    clear_drops_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[g] && (clr_sw_i[g] || clr_hw_i[g])) |=> !flag_o[g]);

    hold_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[g] && !clr_sw_i[g] && !clr_hw_i[g]) |=> $stable(flag_o[g]));
  end
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end

  // R6
  en_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == $past(wdata_i)));
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_vec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] act_i,
  output logic [N_SRC-1:0] gnt_o,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o
);
  always_comb begin
    gnt_o = '0;
    vec_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (act_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        vec_o    = vec_of(i);
      end
    end
  end

  assign req_o = |act_i;

  // R9
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && ((gnt_o & ~act_i) == '0));

  // R8
  idle_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> (vec_o == '0));
endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit
  import irq_vec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EXT-1:0]  ext_evt_i,
  input  logic [N_TMR-1:0]  tmr_req_i,
  input  logic              gie_i,
  input  logic              reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_req_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  input  logic              irq_ack_i
);
  logic [N_EXT-1:0]  flag, clr_sw, clr_hw;
  logic [DATA_W-1:0] en_q, flag_rd;
  logic [N_SRC-1:0]  pend, act, gnt;

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    assign clr_sw[g] = reg_wr_i && !reg_addr_i && reg_wdata_i[flag_pos(g)];
    assign pend[g]   = flag[g];
  end
  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    assign pend[N_EXT+t] = tmr_req_i[t];
  end
  for (genvar s = 0; s < N_SRC; s++) begin : g_act
    assign act[s] = gie_i && pend[s] && en_q[en_pos(s)];
  end

  assign clr_hw = {N_EXT{irq_ack_i}} & gnt[N_EXT-1:0];

  irq_flag_bank #(.N(N_EXT)) flag_i (
    .clk_i, .rst_ni,
    .set_i(ext_evt_i), .clr_sw_i(clr_sw), .clr_hw_i(clr_hw), .flag_o(flag)
  );

  irq_en_reg #(.W(DATA_W)) en_i (
    .clk_i, .rst_ni,
    .we_i(reg_wr_i && reg_addr_i), .wdata_i(reg_wdata_i), .q_o(en_q)
  );

  irq_prio_arb arb_i (
    .clk_i, .rst_ni,
    .act_i(act), .gnt_o(gnt), .req_o(irq_req_o), .vec_o(irq_vec_o)
  );

  always_comb begin
    flag_rd = '0;
    for (int e = 0; e < N_EXT; e++) flag_rd[flag_pos(e)] = flag[e];
  end

  assign reg_rdata_o = reg_addr_i ? en_q : flag_rd;

  // R3
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_addr_i |-> (reg_rdata_o[4:0] == '0));

  // R7
  gie_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> !irq_req_o);

  // R10
  ack_only_granted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && ext_evt_i == '0 && !reg_wr_i) |=>
      (flag == ($past(flag) & ~$past(gnt[N_EXT-1:0]))));
endmodule

// File: tb/irq_vec_unit_tb_top.sv
module irq_vec_unit_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] ext_evt_i = '0;
  logic [1:0] tmr_req_i = '0;
  logic       gie_i = 1'b0;
  logic       reg_addr_i = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       irq_req_o;
  logic [7:0] irq_vec_o;
  logic       irq_ack_i = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #10 clk_i = ~clk_i;

  irq_vec_unit dut_i (.*);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_err++;
      $display("FAIL watchdog: run hung at cycle %0d", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_addr_i = a; reg_wr_i = 1'b1; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr_i = a; #2; d = reg_rdata_o;
  endtask

  task automatic evt(input logic [2:0] e);
    ext_evt_i = e;
    @(negedge clk_i);
    ext_evt_i = '0;
  endtask

  typedef struct packed {
    logic       gie;
    logic [7:0] en;
    logic [1:0] tmr;
    logic [2:0] ext;
    logic       req;
    logic [7:0] vec;
  } vec_t;

  localparam int N_VEC = 11;
  localparam vec_t TBL [N_VEC] = '{
    '{1'b1, 8'h07, 2'b00, 3'b001, 1'b1, 8'h02},
    '{1'b1, 8'h07, 2'b00, 3'b110, 1'b1, 8'h04},
    '{1'b1, 8'h07, 2'b00, 3'b100, 1'b1, 8'h06},
    '{1'b1, 8'h40, 2'b01, 3'b000, 1'b1, 8'h0E},
    '{1'b1, 8'h80, 2'b10, 3'b000, 1'b1, 8'h12},
    '{1'b1, 8'hC0, 2'b11, 3'b000, 1'b1, 8'h0E},
    '{1'b0, 8'hFF, 2'b11, 3'b111, 1'b0, 8'h00},
    '{1'b1, 8'h00, 2'b11, 3'b111, 1'b0, 8'h00},
    '{1'b1, 8'hFE, 2'b11, 3'b111, 1'b1, 8'h04},
    '{1'b1, 8'h84, 2'b10, 3'b101, 1'b1, 8'h06},
    '{1'b1, 8'h80, 2'b11, 3'b111, 1'b1, 8'h12}
  };

  initial begin
    logic [7:0] d;
    #35 rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(1'b0, d); chk("R1 flags", 16'(d), 16'h00);
    rd(1'b1, d); chk("R1 enables", 16'(d), 16'h00);
    chk("R1 req", 16'(irq_req_o), 16'h0);
    chk("R1 vec", 16'(irq_vec_o), 16'h00);

    // R2 R7 R8 R9 vector walk
    for (int i = 0; i < N_VEC; i++) begin
      gie_i = 1'b0; tmr_req_i = '0;
      wr(1'b0, 8'hE0);
      wr(1'b1, TBL[i].en);
      evt(TBL[i].ext);
      rd(1'b0, d);
      chk("R2 flag map", 16'(d), 16'({TBL[i].ext[1], TBL[i].ext[0], TBL[i].ext[2], 5'b0}));
      gie_i = TBL[i].gie; tmr_req_i = TBL[i].tmr; #2;
      chk("R7 R9 req", 16'(irq_req_o), 16'(TBL[i].req));
      chk("R8 R9 vec", 16'(irq_vec_o), 16'(TBL[i].vec));
    end
    gie_i = 1'b0; tmr_req_i = '0;
    wr(1'b0, 8'hE0);

    // R6 enable readback
    wr(1'b1, 8'hA5); rd(1'b1, d); chk("R6 en A5", 16'(d), 16'hA5);
    wr(1'b1, 8'h5A); rd(1'b1, d); chk("R6 en 5A", 16'(d), 16'h5A);

    // R3 reserved bits
    evt(3'b111);
    wr(1'b0, 8'h1F); rd(1'b0, d); chk("R3 rsvd write ignored", 16'(d), 16'hE0);

    // R4 selective clear
    wr(1'b0, 8'h40); rd(1'b0, d); chk("R4 clear src0 only", 16'(d), 16'hA0);
    wr(1'b0, 8'h00); rd(1'b0, d); chk("R4 zero write keeps", 16'(d), 16'hA0);

    // R5 event beats clear
    ext_evt_i = 3'b010; wr(1'b0, 8'hE0); ext_evt_i = '0;
    rd(1'b0, d); chk("R5 set wins", 16'(d), 16'h80);
    wr(1'b0, 8'hE0);

    // R10 acknowledge
    wr(1'b1, 8'h47); gie_i = 1'b1; tmr_req_i = 2'b01;
    evt(3'b111); #2;
    chk("R10 first vec", 16'(irq_vec_o), 16'h02);
    irq_ack_i = 1'b1; @(negedge clk_i); irq_ack_i = 1'b0;
    rd(1'b0, d); chk("R10 only src0 cleared", 16'(d), 16'hA0);
    chk("R10 next vec", 16'(irq_vec_o), 16'h04);
    irq_ack_i = 1'b1; ext_evt_i = 3'b010; @(negedge clk_i);
    irq_ack_i = 1'b0; ext_evt_i = '0;
    rd(1'b0, d); chk("R10 event beats ack", 16'(d), 16'hA0);
    irq_ack_i = 1'b1; @(negedge clk_i);
    irq_ack_i = 1'b1; @(negedge clk_i); irq_ack_i = 1'b0;
    rd(1'b0, d); chk("R10 all ext cleared", 16'(d), 16'h00);
    chk("R10 timer level kept", 16'(irq_vec_o), 16'h0E);
    irq_ack_i = 1'b1; @(negedge clk_i); irq_ack_i = 1'b0; #2;
    chk("R10 timer ack no effect", 16'(irq_req_o), 16'h1);
    tmr_req_i = '0; #2;
    chk("R8 idle vec", 16'(irq_vec_o), 16'h00);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule